// File: doc/BRIEF.md
# Virtual-Channel Link Transmit Scheduler

This block decides, cycle by cycle, what the 16-bit serial-link transmit word carries. Four traffic classes share the link, each with its own virtual channel: deterministic-latency messages, control packets, data packets and link administration characters (ACK/NACK). A deterministic-latency request lands on the wire a fixed number of cycles after it is raised, even in the middle of a packet. The interrupted packet then carries on without losing or repeating a word.

Control packets are reliable. A whole control packet is first captured into a local replay buffer. It is sent from there and kept until the far end acknowledges it. A negative acknowledge, or no answer within a timeout, sends it again in full. Data packets are sent once, straight from their stream, and never kept. When nothing is pending, the link carries the IDLE control symbol. Every output word comes with a flag that marks control symbols apart from payload.

Top module: `vc_tx_sched`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after it, `tx_word` is IDLE (16'h1C1C) with `tx_ctrl`=1, `ctl_ready`=1 and `dat_ready`=0.
- R2: When no channel has anything to send, the output is IDLE (16'h1C1C) with `tx_ctrl`=1.
- R3: A `dlm_req` sampled at clock edge k makes the output after edge k+1 equal {8'hE7, `dlm_code`} with `tx_ctrl`=1. This slot is independent of any other traffic.
- R4: A packet interrupted by a deterministic-latency word resumes on the following cycle. No payload word is lost or duplicated, and the streams are not accepted during the inserted cycle.
- R5: Each packet is framed as a start symbol, its payload words and then the end symbol 16'h7C7C. The start symbol is 16'h5C5C for control and 16'h5D5D for data. Framing symbols have `tx_ctrl`=1 and payload words have `tx_ctrl`=0. A gap in the data stream inside a packet is filled with IDLE.
- R6: Between packets the order of choice is: pending ACK character (16'h3A3A), then pending NACK character (16'h3B3B), then a held control packet, then data. A started packet is never preempted by another packet.
- R7: `ctl_ready` is high only while the replay buffer is empty and loading. A control packet ends at its `ctl_last` word or at its 32nd word, whichever comes first. After that, `ctl_ready` stays low until the packet is released.
- R8: An `ack_rx` received after a control packet's end symbol has been sent releases the packet, and `ctl_ready` is high in the next cycle.
- R9: A `nack_rx` received after the end symbol has been sent makes the whole control packet go out again, framing included.
- R10: If neither `ack_rx` nor `nack_rx` arrives, the control packet's start symbol is sent again exactly TIMEOUT+1 cycles after its end symbol, which is 1025 cycles by default.
- R11: Data packets are sent exactly once. `ack_rx` and `nack_rx` cause no data resend and no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dlm_req | input | 1 | One-cycle request to send a deterministic-latency word |
| dlm_code | input | 8 | Payload byte of the deterministic-latency word |
| ctl_valid | input | 1 | Control stream word valid |
| ctl_data | input | 16 | Control stream word |
| ctl_last | input | 1 | Final word of the control packet |
| ctl_ready | output | 1 | Replay buffer accepts a control word |
| dat_valid | input | 1 | Data stream word valid |
| dat_data | input | 16 | Data stream word |
| dat_last | input | 1 | Final word of the data packet |
| dat_ready | output | 1 | Data word taken onto the link this cycle |
| ack_rx | input | 1 | Decoded ACK received for the outstanding control packet |
| nack_rx | input | 1 | Decoded NACK received for the outstanding control packet |
| adm_ack_req | input | 1 | Request to emit an ACK administration character |
| adm_nack_req | input | 1 | Request to emit a NACK administration character |
| tx_word | output | 16 | Transmit word |
| tx_ctrl | output | 1 | Transmit word is a control symbol |

## Verification
The hardest case to reach from the ports is a single packet boundary where every class competes at once. At that boundary both administration characters are pending, a control packet is held complete in the replay buffer and the next data packet is already valid. The stimulus gets there by starting a long data packet first. While that packet is still on the wire, both administration requests are pulsed and a short control packet is loaded, so that all of them wait at the same end symbol. The retransmit timeout is reached by leaving a sent control packet unanswered, after a NACK-driven resend, and timing the gap between its end symbol and the next start symbol.

// File: rtl/vc_tx_pkg.sv
// Package: symbol codes and state types shared by the transmit scheduler.
// Assumes a 16-bit link word; control symbols are marked by the ctrl flag.
package vc_tx_pkg;
    localparam int WORD_W     = 16;
    localparam int DLM_CODE_W = WORD_W - 8;

    localparam logic [WORD_W-1:0] SYM_IDLE    = 16'h1C1C;
    localparam logic [WORD_W-1:0] SYM_ACK     = 16'h3A3A;
    localparam logic [WORD_W-1:0] SYM_NACK    = 16'h3B3B;
    localparam logic [WORD_W-1:0] SYM_SOP_CTL = 16'h5C5C;
    localparam logic [WORD_W-1:0] SYM_SOP_DAT = 16'h5D5D;
    localparam logic [WORD_W-1:0] SYM_EOP     = 16'h7C7C;
    localparam logic [7:0]        DLM_MARK    = 8'hE7;

    typedef enum logic [2:0] {
        ST_GAP, ST_CTL, ST_CTL_END, ST_DAT, ST_DAT_END
    } arb_state_t;

    typedef enum logic [1:0] {
        RB_LOAD, RB_HELD, RB_SEND, RB_WAIT
    } rb_state_t;
endpackage

// File: rtl/vc_dlm_stage.sv
// Deterministic-latency request stage: one register between the request
// and the arbiter, giving a fixed two-edge request-to-wire latency.
// Assumes requests are single-cycle pulses; back-to-back pulses are kept.
module vc_dlm_stage
    import vc_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [DLM_CODE_W-1:0] code,
    output logic                  pend,
    output logic [DLM_CODE_W-1:0] pend_code
);
    // Capture the request and its code for the arbiter's next decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_code <= '0;
        end else begin
            pend      <= req;
            pend_code <= code;
        end
    end
endmodule

// File: rtl/vc_admin_pend.sv
// Administration character pending flags (index 0 = ACK, 1 = NACK).
// A request sets its flag; the arbiter clears it when the character goes out.
// Assumes take is only raised while the flag is set.
module vc_admin_pend #(
    parameter int NUM_CHR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CHR-1:0] req_v,
    input  logic [NUM_CHR-1:0] take_v,
    output logic [NUM_CHR-1:0] pend_v
);
    for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
        logic flag_q;

        // Hold a request until the arbiter has emitted its character.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~take_v[g]) | req_v[g];
        end

        assign pend_v[g] = flag_q;

        // R6: an administration character is emitted only when one is pending
        p_take_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
            take_v[g] |-> flag_q);
    end
endmodule

// File: rtl/vc_ctl_replay.sv
// Control-channel replay buffer: loads one complete control packet, offers
// it to the arbiter, and keeps it until ACK. NACK or timeout offers it again.
// Assumes the arbiter raises start only when pkt_avail is high, steps adv
// once per payload word, and pulses sent when the end symbol goes out.
module vc_ctl_replay
    import vc_tx_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              ack_rx,
    input  logic              nack_rx,
    output logic              pkt_avail,
    input  logic              start,
    input  logic              adv,
    input  logic              sent,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_last
);
    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(TIMEOUT);

    rb_state_t         state;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     last_idx;
    logic [TW-1:0]     timer;

    assign in_ready  = (state == RB_LOAD);
    assign pkt_avail = (state == RB_HELD);
    assign rd_word   = mem[rd_ptr];
    assign rd_last   = (rd_ptr == last_idx);

    // Store each accepted control word at the write pointer.
    always_ff @(posedge clk) begin
        if (in_ready && in_valid) mem[wr_ptr] <= in_data;
    end

    // Packet life cycle: load, hold, send, wait for the far end's verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RB_LOAD;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            last_idx <= '0;
            timer    <= '0;
        end else begin
            case (state)
                RB_LOAD: begin
                    if (in_valid) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        if (in_last || wr_ptr == AW'(DEPTH - 1)) begin
                            last_idx <= wr_ptr;
                            state    <= RB_HELD;
                        end
                    end
                end
                RB_HELD: begin
                    if (start) begin
                        rd_ptr <= '0;
                        state  <= RB_SEND;
                    end
                end
                RB_SEND: begin
                    if (adv && !rd_last) rd_ptr <= rd_ptr + 1'b1;
                    if (sent) begin
                        timer <= '0;
                        state <= RB_WAIT;
                    end
                end
                RB_WAIT: begin
                    if (ack_rx) begin
                        wr_ptr <= '0;
                        state  <= RB_LOAD;
                    end else if (nack_rx || timer == TW'(TIMEOUT - 1)) begin
                        state <= RB_HELD;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= RB_LOAD;
            endcase
        end
    end

    // R7: the arbiter starts a control packet only when one is held
    p_start_needs_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> pkt_avail);

    // R8: loading resumes only because an ACK arrived
    p_load_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(ack_rx));

    // R9/R10: a packet already sent is offered again only on NACK or timeout
    p_resend_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pkt_avail) && $past(state == RB_WAIT)) |->
            ($past(nack_rx) || $past(timer) == TW'(TIMEOUT - 1)));

    // R4: reads stay inside the stored packet while sending
    p_rd_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RB_SEND) |-> (rd_ptr <= last_idx));
endmodule

// File: rtl/vc_tx_sched.sv
// Virtual-channel transmit scheduler (top). Each cycle it chooses one
// 16-bit word: a deterministic-latency word has absolute priority; between
// packets, ACK, NACK, held control and data are chosen in that order; inside
// a packet only that packet's words or IDLE fill are sent. Output is
// registered. Assumes ack_rx/nack_rx refer to the outstanding control packet.
module vc_tx_sched
    import vc_tx_pkg::*;
#(
    parameter int CTL_DEPTH   = 32,
    parameter int CTL_TIMEOUT = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dlm_req,
    input  logic [DLM_CODE_W-1:0] dlm_code,
    input  logic                  ctl_valid,
    input  logic [WORD_W-1:0]     ctl_data,
    input  logic                  ctl_last,
    output logic                  ctl_ready,
    input  logic                  dat_valid,
    input  logic [WORD_W-1:0]     dat_data,
    input  logic                  dat_last,
    output logic                  dat_ready,
    input  logic                  ack_rx,
    input  logic                  nack_rx,
    input  logic                  adm_ack_req,
    input  logic                  adm_nack_req,
    output logic [WORD_W-1:0]     tx_word,
    output logic                  tx_ctrl
);
    arb_state_t            state, nxt_state;
    logic [WORD_W-1:0]     nxt_word;
    logic                  nxt_ctrl;
    logic                  dlm_pend;
    logic [DLM_CODE_W-1:0] dlm_pcode;
    logic [1:0]            adm_pend, adm_take;
    logic                  c_avail, c_start, c_adv, c_sent, c_last;
    logic [WORD_W-1:0]     c_word;
    logic                  d_take;

    vc_dlm_stage u_dlm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (dlm_req),
        .code      (dlm_code),
        .pend      (dlm_pend),
        .pend_code (dlm_pcode)
    );

    vc_admin_pend #(.NUM_CHR(2)) u_adm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_v  ({adm_nack_req, adm_ack_req}),
        .take_v (adm_take),
        .pend_v (adm_pend)
    );

    vc_ctl_replay #(.DEPTH(CTL_DEPTH), .TIMEOUT(CTL_TIMEOUT)) u_replay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ctl_valid),
        .in_data   (ctl_data),
        .in_last   (ctl_last),
        .in_ready  (ctl_ready),
        .ack_rx    (ack_rx),
        .nack_rx   (nack_rx),
        .pkt_avail (c_avail),
        .start     (c_start),
        .adv       (c_adv),
        .sent      (c_sent),
        .rd_word   (c_word),
        .rd_last   (c_last)
    );

    assign dat_ready = d_take;

    // Pick this cycle's word and the channel that advances.
    always_comb begin
        nxt_state = state;
        nxt_word  = SYM_IDLE;
        nxt_ctrl  = 1'b1;
        d_take    = 1'b0;
        c_start   = 1'b0;
        c_adv     = 1'b0;
        c_sent    = 1'b0;
        adm_take  = 2'b00;
        if (dlm_pend) begin
            nxt_word = {DLM_MARK, dlm_pcode};
        end else begin
            case (state)
                ST_GAP: begin
                    if (adm_pend[0]) begin
                        nxt_word    = SYM_ACK;
                        adm_take[0] = 1'b1;
                    end else if (adm_pend[1]) begin
                        nxt_word    = SYM_NACK;
                        adm_take[1] = 1'b1;
                    end else if (c_avail) begin
                        nxt_word  = SYM_SOP_CTL;
                        c_start   = 1'b1;
                        nxt_state = ST_CTL;
                    end else if (dat_valid) begin
                        nxt_word  = SYM_SOP_DAT;
                        nxt_state = ST_DAT;
                    end
                end
                ST_CTL: begin
                    nxt_word = c_word;
                    nxt_ctrl = 1'b0;
                    c_adv    = 1'b1;
                    if (c_last) nxt_state = ST_CTL_END;
                end
                ST_CTL_END: begin
                    nxt_word  = SYM_EOP;
                    c_sent    = 1'b1;
                    nxt_state = ST_GAP;
                end
                ST_DAT: begin
                    if (dat_valid) begin
                        nxt_word = dat_data;
                        nxt_ctrl = 1'b0;
                        d_take   = 1'b1;
                        if (dat_last) nxt_state = ST_DAT_END;
                    end
                end
                ST_DAT_END: begin
                    nxt_word  = SYM_EOP;
                    nxt_state = ST_GAP;
                end
                default: nxt_state = ST_GAP;
            endcase
        end
    end

    // Register the chosen word and the scheduler state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_GAP;
            tx_word <= SYM_IDLE;
            tx_ctrl <= 1'b1;
        end else begin
            state   <= nxt_state;
            tx_word <= nxt_word;
            tx_ctrl <= nxt_ctrl;
        end
    end

    // R3: a request reaches the wire exactly two edges later with its code
    p_dlm_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dlm_req |=> ##1 (tx_ctrl && tx_word == {DLM_MARK, $past(dlm_code, 2)}));

    // R4: no stream word is accepted in an inserted deterministic-latency cycle
    p_no_take_in_dlm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dlm_pend |-> (!dat_ready && !c_adv));

    // R5: payload words never carry the control flag on the data stream path
    p_payload_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |=> !tx_ctrl);
endmodule

// File: tb/vc_tx_sched_test.sv
`timescale 1ns/1ps
module vc_tx_sched_test;
    import vc_tx_pkg::*;

    localparam int TMO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlm_req = 1'b0;
    logic [7:0]  dlm_code = '0;
    logic        ctl_valid = 1'b0, ctl_last = 1'b0;
    logic [15:0] ctl_data = '0;
    logic        ctl_ready;
    logic        dat_valid = 1'b0, dat_last = 1'b0;
    logic [15:0] dat_data = '0;
    logic        dat_ready;
    logic        ack_rx = 1'b0, nack_rx = 1'b0;
    logic        adm_ack_req = 1'b0, adm_nack_req = 1'b0;
    logic [15:0] tx_word;
    logic        tx_ctrl;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int eop_cyc = 0;
    int sop_gap = 0;
    int dlm_seen = 0;
    logic [16:0] exp_q[$];

    always #2.5 clk = ~clk;

    vc_tx_sched #(.CTL_DEPTH(32), .CTL_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .dlm_req(dlm_req), .dlm_code(dlm_code),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last),
        .ctl_ready(ctl_ready), .dat_valid(dat_valid), .dat_data(dat_data),
        .dat_last(dat_last), .dat_ready(dat_ready), .ack_rx(ack_rx),
        .nack_rx(nack_rx), .adm_ack_req(adm_ack_req),
        .adm_nack_req(adm_nack_req), .tx_word(tx_word), .tx_ctrl(tx_ctrl)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic c, input logic [15:0] w);
        exp_q.push_back({c, w});
    endtask

    task automatic exp_pkt(input bit is_ctl, input int n, input logic [15:0] base);
        push(1'b1, is_ctl ? SYM_SOP_CTL : SYM_SOP_DAT);
        for (int i = 0; i < n; i++) push(1'b0, base + 16'(i));
        push(1'b1, SYM_EOP);
    endtask

    // Monitor: pops expected items for every non-idle, non-DLM output word.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (tx_ctrl && tx_word == SYM_IDLE) begin
            end else if (tx_ctrl && tx_word[15:8] == DLM_MARK) begin
                dlm_seen++;
            end else begin
                if (tx_ctrl && tx_word == SYM_EOP) eop_cyc = cyc;
                if (tx_ctrl && tx_word == SYM_SOP_CTL) sop_gap = cyc - eop_cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R11 unexpected word", {15'd0, tx_ctrl, tx_word}, 32'h0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk({tx_ctrl, tx_word} == e, "R4/R5/R6 stream order",
                        {15'd0, tx_ctrl, tx_word}, {15'd0, e});
                end
            end
        end
    end

    task automatic send_dat(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            bit r;
            @(negedge clk);
            dat_valid = 1'b1;
            dat_data  = base + 16'(i);
            dat_last  = (i == n - 1);
            forever begin
                #1 r = dat_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
        end
    endtask

    task automatic dat_stop();
        @(negedge clk);
        dat_valid = 1'b0;
        dat_last  = 1'b0;
    endtask

    task automatic send_ctl(input int n, input logic [15:0] base, input bit term);
        for (int i = 0; i < n; i++) begin
            bit r;
            @(negedge clk);
            ctl_valid = 1'b1;
            ctl_data  = base + 16'(i);
            ctl_last  = term && (i == n - 1);
            forever begin
                #1 r = ctl_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
        end
    endtask

    task automatic ctl_stop();
        @(negedge clk);
        ctl_valid = 1'b0;
        ctl_last  = 1'b0;
    endtask

    task automatic dlm_shot(input logic [7:0] code);
        @(negedge clk);
        dlm_req  = 1'b1;
        dlm_code = code;
        @(negedge clk);
        dlm_req = 1'b0;
        @(negedge clk);
        chk(tx_ctrl && tx_word == {DLM_MARK, code}, "R3 dlm slot",
            {15'd0, tx_ctrl, tx_word}, {16'd1, DLM_MARK, code});
    endtask

    task automatic drain(input int maxc);
        for (int i = 0; i < maxc && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack_rx = 1'b1;
        @(negedge clk) ack_rx = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk(tx_word == SYM_IDLE, "R1 reset word", tx_word, SYM_IDLE);
        chk(tx_ctrl == 1'b1, "R1 reset ctrl", tx_ctrl, 1);
        chk(ctl_ready == 1'b1, "R1 reset ctl_ready", ctl_ready, 1);
        chk(dat_ready == 1'b0, "R1 reset dat_ready", dat_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_ctrl && tx_word == SYM_IDLE, "R2 idle fill", tx_word, SYM_IDLE);

        // R3: standalone deterministic-latency word
        d0 = dlm_seen;
        dlm_shot(8'h11);
        repeat (2) @(negedge clk);
        chk(dlm_seen == d0 + 1, "R3 single dlm", dlm_seen, d0 + 1);

        // R5: plain data packet framing
        exp_pkt(1'b0, 5, 16'h0100);
        send_dat(5, 16'h0100);
        dat_stop();
        drain(50);

        // R4: two DLM words inside a data packet
        d0 = dlm_seen;
        exp_pkt(1'b0, 8, 16'h0200);
        fork
            begin send_dat(8, 16'h0200); dat_stop(); end
            begin repeat (3) @(negedge clk); dlm_shot(8'h42); dlm_shot(8'h43); end
        join
        drain(50);
        chk(dlm_seen == d0 + 2, "R4 dlm count mid-packet", dlm_seen, d0 + 2);

        // R7/R9/R10/R8: control packet replay
        exp_pkt(1'b1, 3, 16'h0300);
        send_ctl(3, 16'h0300, 1'b1);
        ctl_stop();
        chk(ctl_ready == 1'b0, "R7 ready low once held", ctl_ready, 0);
        drain(50);
        chk(ctl_ready == 1'b0, "R8 held until ack", ctl_ready, 0);
        exp_pkt(1'b1, 3, 16'h0300);
        @(negedge clk) nack_rx = 1'b1;
        @(negedge clk) nack_rx = 1'b0;
        drain(50);
        exp_pkt(1'b1, 3, 16'h0300);
        drain(TMO + 100);
        chk(sop_gap == TMO + 1, "R10 timeout gap", sop_gap, TMO + 1);
        pulse_ack();
        chk(ctl_ready == 1'b1, "R8 released by ack", ctl_ready, 1);
        repeat (TMO + 20) @(negedge clk);
        chk(exp_q.size() == 0 && tx_word == SYM_IDLE, "R8 no resend after ack",
            tx_word, SYM_IDLE);

        // R7: 32-word control packet without last ends by itself
        exp_pkt(1'b1, 32, 16'h0400);
        send_ctl(32, 16'h0400, 1'b0);
        ctl_stop();
        chk(ctl_ready == 1'b0, "R7 full buffer closes packet", ctl_ready, 0);
        drain(100);
        pulse_ack();

        // R6: ACK, NACK, control and data all waiting at one boundary
        exp_pkt(1'b0, 8, 16'h0500);
        push(1'b1, SYM_ACK);
        push(1'b1, SYM_NACK);
        exp_pkt(1'b1, 2, 16'h0600);
        exp_pkt(1'b0, 2, 16'h0700);
        fork
            begin send_dat(8, 16'h0500); send_dat(2, 16'h0700); dat_stop(); end
            begin
                repeat (2) @(negedge clk);
                adm_ack_req = 1'b1;
                adm_nack_req = 1'b1;
                @(negedge clk);
                adm_ack_req = 1'b0;
                adm_nack_req = 1'b0;
                send_ctl(2, 16'h0600, 1'b1);
                ctl_stop();
            end
        join
        drain(80);
        pulse_ack();

        // R11: receive verdicts do not resend data
        exp_pkt(1'b0, 3, 16'h0800);
        send_dat(3, 16'h0800);
        dat_stop();
        drain(50);
        @(negedge clk) nack_rx = 1'b1;
        @(negedge clk) begin nack_rx = 1'b0; ack_rx = 1'b1; end
        @(negedge clk) ack_rx = 1'b0;
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0 && tx_ctrl && tx_word == SYM_IDLE, "R11 data sent once",
            tx_word, SYM_IDLE);
        chk(dat_ready == 1'b0, "R11 data idle", dat_ready, 0);
        chk(ctl_ready == 1'b1, "R11 control empty", ctl_ready, 1);

        finish_run();
    end
endmodule